// File: doc/BRIEF.md
# Three-Stage Floating-Point Multiplier

This block multiplies two numbers held in a custom floating-point format and returns one product per clock cycle after a fixed latency of three cycles. Each operand has three parts: a sign bit, an 8-bit exponent stored with a bias of 128, and a 56-bit magnitude fraction. The fraction has a hidden leading one, so the full mantissa is the fraction `0.1f` and lies in [0.5, 1). An exponent field of zero is reserved as the encoding of the value zero.

The work is split across three register stages. The first stage forms the partial products of the mantissas and works out the zero, sign and biased exponent sum. The second stage reduces the partial products to two vectors. The third stage adds those vectors, normalizes with at most one left shift, rounds at the first guard bit and saturates the exponent. A valid bit moves through the stages with the data. An exponent that leaves the representable range is flagged on one status output.

Top module: `fpm_mul_pipe`

## Requirements
- R1: An operand with a nonzero exponent field has the value (0.1f in binary) × 2^(exp − 128), where the leading 1 is the hidden bit and f is the 56-bit fraction field. The product is returned in the same format.
- R2: If either operand has an exponent field of 0, the result is all zeros (sign 0, exponent 0, fraction 0) and the range flag is 0.
- R3: When no range error occurs, the sign of a nonzero result is the XOR of the two operand signs.
- R4: Before any adjustment, the result exponent is e1 + e2 − 128.
- R5: If the top bit of the 114-bit mantissa product is 0, the product is shifted left one place and the exponent is decremented by one.
- R6: Rounding adds the guard bit (the bit just below the kept 57-bit mantissa) to the mantissa. If that addition carries out, the mantissa becomes 0.1000…0 (fraction field zero) and the exponent is incremented.
- R7: If the final exponent is above 255, the output has the exponent field 255, the fraction field all ones, the sign of R3, and the range flag set.
- R8: If the final exponent is below 1, the output is all zeros with the range flag set.
- R9: Each accepted input appears at the output with out_valid high exactly three cycles after in_valid was high. Back-to-back inputs give back-to-back outputs in order, and no output appears without an input.
- R10: A synchronous active-high reset clears every stage valid. out_valid is low in the cycle after reset and stays low until new inputs arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | 8 | Biased exponent of operand A |
| a_frac | input | 56 | Fraction of operand A (hidden one not stored) |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | 8 | Biased exponent of operand B |
| b_frac | input | 56 | Fraction of operand B |
| out_valid | output | 1 | Product present this cycle |
| y_sign | output | 1 | Sign of product |
| y_exp | output | 8 | Biased exponent of product |
| y_frac | output | 56 | Fraction of product |
| y_range_err | output | 1 | Exponent overflow or underflow occurred |

## Verification
Some properties are checked on every cycle by the assertions: the three-cycle valid latency, reset flushing the pipeline, the zero-operand result, the sign rule, and the fixed output patterns for overflow and underflow. Other behaviour only shows up in the bench's scenarios, which compare each result against an independent full-width multiply. These cover whether the mantissa bits are right, whether the exponent moves by exactly one on normalization, and the rounding carry that rolls the mantissa over. They also cover a reset that arrives while products are still in flight.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 56;
    localparam int EXP_BIAS = 128;
    localparam int PP_PARTS = 4;

    localparam int MANT_W  = FRAC_W + 1;
    localparam int PROD_W  = 2 * MANT_W;
    localparam int CHUNK_W = (MANT_W + PP_PARTS - 1) / PP_PARTS;
    localparam int PAD_W   = CHUNK_W * PP_PARTS;
    localparam int PP_W    = MANT_W + CHUNK_W;
    localparam int EXPI_W  = EXP_W + 3;
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    typedef logic signed [EXPI_W-1:0] expi_t;
    typedef logic [PP_W-1:0]          pp_t;
    typedef logic [PROD_W-1:0]        prod_t;
    typedef logic [MANT_W-1:0]        mant_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic  zero;
        logic  sign;
        expi_t exp_sum;
    } stage_ctl_t;

    function automatic logic word_is_zero(fp_word_t w);
        return (w.exp == '0);
    endfunction

    function automatic mant_t mant_of(fp_word_t w);
        return {1'b1, w.frac};
    endfunction

    function automatic expi_t exp_join(logic [EXP_W-1:0] e1, logic [EXP_W-1:0] e2);
        expi_t x1;
        expi_t x2;
        x1 = expi_t'({3'b000, e1});
        x2 = expi_t'({3'b000, e2});
        return x1 + x2 - expi_t'(EXP_BIAS);
    endfunction

endpackage

// File: rtl/fpm_ppgen.sv
module fpm_ppgen
    import fpm_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  fp_word_t                      a_word,
    input  fp_word_t                      b_word,
    output logic                          s1_valid,
    output stage_ctl_t                    s1_ctl,
    output logic [PP_PARTS-1:0][PP_W-1:0] s1_pp
);

    mant_t                         ma;
    logic [PAD_W-1:0]              mb_pad;
    logic [PP_PARTS-1:0][PP_W-1:0] pp_n;
    stage_ctl_t                    ctl_n;

    assign ma     = mant_of(a_word);
    assign mb_pad = PAD_W'(mant_of(b_word));

    for (genvar k = 0; k < PP_PARTS; k++) begin : g_pp
        assign pp_n[k] = {{CHUNK_W{1'b0}}, ma} *
                         {{MANT_W{1'b0}}, mb_pad[k*CHUNK_W +: CHUNK_W]};
    end

    always_comb begin
        ctl_n.zero    = word_is_zero(a_word) || word_is_zero(b_word);
        ctl_n.sign    = a_word.sign ^ b_word.sign;
        ctl_n.exp_sum = exp_join(a_word.exp, b_word.exp);
    end

    always_ff @(posedge clk) begin
        if (rst) s1_valid <= 1'b0;
        else     s1_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        s1_ctl <= ctl_n;
        s1_pp  <= pp_n;
    end

endmodule

// File: rtl/fpm_ppreduce.sv
module fpm_ppreduce
    import fpm_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          s1_valid,
    input  stage_ctl_t                    s1_ctl,
    input  logic [PP_PARTS-1:0][PP_W-1:0] s1_pp,
    output logic                          s2_valid,
    output stage_ctl_t                    s2_ctl,
    output prod_t                         s2_even,
    output prod_t                         s2_odd
);

    prod_t even_n;
    prod_t odd_n;

    always_comb begin
        even_n = '0;
        odd_n  = '0;
        for (int k = 0; k < PP_PARTS; k++) begin
            if ((k % 2) == 0)
                even_n = even_n + (prod_t'(s1_pp[k]) << (k * CHUNK_W));
            else
                odd_n  = odd_n  + (prod_t'(s1_pp[k]) << (k * CHUNK_W));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s2_valid <= 1'b0;
        else     s2_valid <= s1_valid;
    end

    always_ff @(posedge clk) begin
        s2_ctl  <= s1_ctl;
        s2_even <= even_n;
        s2_odd  <= odd_n;
    end

endmodule

// File: rtl/fpm_normround.sv
module fpm_normround
    import fpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       s2_valid,
    input  stage_ctl_t s2_ctl,
    input  prod_t      s2_even,
    input  prod_t      s2_odd,
    output logic       out_valid,
    output fp_word_t   y_word,
    output logic       y_range_err
);

    prod_t            full;
    prod_t            norm;
    logic             shift_n;
    mant_t            mhi;
    logic             guard;
    logic [MANT_W:0]  rsum;
    logic             carry;
    mant_t            mant;
    expi_t            exp_f;
    fp_word_t         word_n;
    logic             err_n;
    logic             unused_bits;

    always_comb begin
        full    = s2_even + s2_odd;
        shift_n = ~full[PROD_W-1];
        norm    = shift_n ? (full << 1) : full;
        mhi     = norm[PROD_W-1 -: MANT_W];
        guard   = norm[PROD_W-1-MANT_W];
        rsum    = {1'b0, mhi} + {{MANT_W{1'b0}}, guard};
        carry   = rsum[MANT_W];
        mant    = carry ? rsum[MANT_W:1] : rsum[MANT_W-1:0];
        exp_f   = s2_ctl.exp_sum
                - expi_t'({{(EXPI_W-1){1'b0}}, shift_n})
                + expi_t'({{(EXPI_W-1){1'b0}}, carry});
    end

    assign unused_bits = ^{norm[PROD_W-2-MANT_W:0], mant[MANT_W-1]};

    always_comb begin
        word_n = '0;
        err_n  = 1'b0;
        if (s2_ctl.zero) begin
            word_n = '0;
        end else if (exp_f > expi_t'(EXP_MAX)) begin
            word_n.sign = s2_ctl.sign;
            word_n.exp  = '1;
            word_n.frac = '1;
            err_n       = 1'b1;
        end else if (exp_f < expi_t'(1)) begin
            err_n = 1'b1;
        end else begin
            word_n.sign = s2_ctl.sign;
            word_n.exp  = exp_f[EXP_W-1:0];
            word_n.frac = mant[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= s2_valid;
    end

    always_ff @(posedge clk) begin
        y_word      <= word_n;
        y_range_err <= err_n;
    end

endmodule

// File: rtl/fpm_mul_pipe.sv
module fpm_mul_pipe
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              a_sign,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [FRAC_W-1:0] a_frac,
    input  logic              b_sign,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [FRAC_W-1:0] b_frac,
    output logic              out_valid,
    output logic              y_sign,
    output logic [EXP_W-1:0]  y_exp,
    output logic [FRAC_W-1:0] y_frac,
    output logic              y_range_err
);

    fp_word_t                      a_word;
    fp_word_t                      b_word;
    logic                          s1_valid;
    stage_ctl_t                    s1_ctl;
    logic [PP_PARTS-1:0][PP_W-1:0] s1_pp;
    logic                          s2_valid;
    stage_ctl_t                    s2_ctl;
    prod_t                         s2_even;
    prod_t                         s2_odd;
    fp_word_t                      y_word;

    assign a_word = '{sign: a_sign, exp: a_exp, frac: a_frac};
    assign b_word = '{sign: b_sign, exp: b_exp, frac: b_frac};

    fpm_ppgen u_gen (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .a_word   (a_word),
        .b_word   (b_word),
        .s1_valid (s1_valid),
        .s1_ctl   (s1_ctl),
        .s1_pp    (s1_pp)
    );

    fpm_ppreduce u_red (
        .clk      (clk),
        .rst      (rst),
        .s1_valid (s1_valid),
        .s1_ctl   (s1_ctl),
        .s1_pp    (s1_pp),
        .s2_valid (s2_valid),
        .s2_ctl   (s2_ctl),
        .s2_even  (s2_even),
        .s2_odd   (s2_odd)
    );

    fpm_normround u_fin (
        .clk         (clk),
        .rst         (rst),
        .s2_valid    (s2_valid),
        .s2_ctl      (s2_ctl),
        .s2_even     (s2_even),
        .s2_odd      (s2_odd),
        .out_valid   (out_valid),
        .y_word      (y_word),
        .y_range_err (y_range_err)
    );

    assign y_sign = y_word.sign;
    assign y_exp  = y_word.exp;
    assign y_frac = y_word.frac;

endmodule

// File: rtl/fpm_mul_chk.sv
module fpm_mul_chk
    import fpm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              a_sign,
    input logic [EXP_W-1:0]  a_exp,
    input logic              b_sign,
    input logic [EXP_W-1:0]  b_exp,
    input logic              out_valid,
    input logic              y_sign,
    input logic [EXP_W-1:0]  y_exp,
    input logic [FRAC_W-1:0] y_frac,
    input logic              y_range_err
);

    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst)               warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R9: output valid follows input valid by exactly three cycles
    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R10: reset empties the pipeline
    p_flush_r10: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R2: a zero operand yields the all-zero word
    p_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (a_exp == '0 || b_exp == '0)) |->
        ##3 (out_valid && y_exp == '0 && y_frac == '0 && !y_sign && !y_range_err));

    // R3: sign of a nonzero product is the XOR of the operand signs
    p_sign_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && a_exp != '0 && b_exp != '0) |->
        ##3 (out_valid && ((y_sign == $past(a_sign ^ b_sign, 3)) || (y_range_err && y_exp == '0))));

    // R7: overflow saturates exponent and fraction
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && y_range_err && y_exp != '0) |-> (y_exp == '1 && y_frac == '1));

    // R8: underflow gives the positive zero word
    p_underflow_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && y_range_err && y_exp == '0) |-> (y_frac == '0 && !y_sign));

endmodule

bind fpm_mul_pipe fpm_mul_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .a_sign      (a_sign),
    .a_exp       (a_exp),
    .b_sign      (b_sign),
    .b_exp       (b_exp),
    .out_valid   (out_valid),
    .y_sign      (y_sign),
    .y_exp       (y_exp),
    .y_frac      (y_frac),
    .y_range_err (y_range_err)
);

// File: tb/fpm_mul_pipe_tb_top.sv
module fpm_mul_pipe_tb_top;

    typedef struct packed {
        logic        s;
        logic [7:0]  e;
        logic [55:0] f;
        logic        err;
    } res_t;

    typedef struct {
        res_t  r;
        int    due;
        string req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        a_sign = 1'b0, b_sign = 1'b0;
    logic [7:0]  a_exp = '0, b_exp = '0;
    logic [55:0] a_frac = '0, b_frac = '0;
    logic        out_valid, y_sign, y_range_err;
    logic [7:0]  y_exp;
    logic [55:0] y_frac;

    int    cyc = 0;
    int    nchk = 0;
    int    nfail = 0;
    bit    done = 1'b0;
    item_t scb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fpm_mul_pipe dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac),
        .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac),
        .out_valid(out_valid), .y_sign(y_sign), .y_exp(y_exp),
        .y_frac(y_frac), .y_range_err(y_range_err)
    );

    function automatic res_t ref_mul(logic as, logic [7:0] ae, logic [55:0] af,
                                     logic bs, logic [7:0] be, logic [55:0] bf);
        logic [113:0] p;
        logic [57:0]  rs;
        int           e;
        if (ae == 0 || be == 0) return '0;
        p = 114'({1'b1, af}) * 114'({1'b1, bf});
        e = int'(ae) + int'(be) - 128;
        if (!p[113]) begin p = p << 1; e = e - 1; end
        rs = {1'b0, p[113:57]} + 58'(p[56]);
        if (rs[57]) begin rs = rs >> 1; e = e + 1; end
        if (e > 255)    return {as ^ bs, 8'hFF, {56{1'b1}}, 1'b1};
        else if (e < 1) return {1'b0, 8'h00, 56'h0, 1'b1};
        return {as ^ bs, e[7:0], rs[55:0], 1'b0};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    task automatic send(logic as, logic [7:0] ae, logic [55:0] af,
                        logic bs, logic [7:0] be, logic [55:0] bf, string req);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        a_sign = as; a_exp = ae; a_frac = af;
        b_sign = bs; b_exp = be; b_frac = bf;
        it.r   = ref_mul(as, ae, af, bs, be, bf);
        it.due = cyc + 3;
        it.req = req;
        scb.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: pop and compare as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (scb.size() == 0) begin
                    chk(1'b0, "R9", "output without input", 64'(out_valid), 64'(0));
                end else begin
                    item_t it;
                    it = scb.pop_front();
                    chk(it.due == cyc, "R9", "latency", 64'(cyc), 64'(it.due));
                    chk(y_sign == it.r.s, it.req, "sign", 64'(y_sign), 64'(it.r.s));
                    chk(y_exp == it.r.e, it.req, "exponent", 64'(y_exp), 64'(it.r.e));
                    chk(y_frac == it.r.f, it.req, "fraction", 64'(y_frac), 64'(it.r.f));
                    chk(y_range_err == it.r.err, it.req, "range flag",
                        64'(y_range_err), 64'(it.r.err));
                end
            end else if (scb.size() != 0 && scb[0].due == cyc) begin
                chk(1'b0, "R9", "missing output", 64'(0), 64'(1));
                void'(scb.pop_front());
            end
        end
    end

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid during reset", 64'(out_valid), 64'(0));
        rst = 1'b0;
        idle(2);
        chk(out_valid == 1'b0, "R10", "out_valid after reset", 64'(out_valid), 64'(0));

        // R1 R4 R5: 1.0 x 1.0 needs a left shift (0.5 * 0.5 = 0.25)
        send(0, 8'd129, 56'h0, 0, 8'd129, 56'h0, "R5");
        // R4: 0.75 x 0.75 = 0.5625, no shift
        send(0, 8'd130, 56'h80000000000000, 1, 8'd120, 56'h80000000000000, "R4");
        // R6: rounding carry rolls the mantissa over
        send(1, 8'd140, 56'h80000000000000, 0, 8'd100, 56'h55555555555555, "R6");
        // R2: zero operands, signs set to show the sign is cleared
        send(1, 8'd0, 56'h123456789ABCDE, 1, 8'd200, 56'hFFFF, "R2");
        send(1, 8'd77, 56'h0F0F0F0F0F0F0F, 0, 8'd0, 56'h0, "R2");
        // R7: overflow
        send(1, 8'd255, 56'hFFFFFFFFFFFFFF, 0, 8'd255, 56'hFFFFFFFFFFFFFF, "R7");
        send(0, 8'd200, 56'h0, 0, 8'd190, 56'h0, "R7");
        // R8: underflow
        send(1, 8'd1, 56'h0, 0, 8'd1, 56'h0, "R8");
        send(0, 8'd60, 56'h10, 1, 8'd68, 56'h20, "R8");
        // R3: all sign pairs
        send(0, 8'd128, 56'hABCDEF, 1, 8'd128, 56'h12345, "R3");
        send(1, 8'd128, 56'hABCDEF, 1, 8'd128, 56'h12345, "R3");
        send(1, 8'd128, 56'hABCDEF, 0, 8'd128, 56'h12345, "R3");
        idle(5);

        // R1 R9: random stream with occasional bubbles
        for (int i = 0; i < 300; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            send(ra[63], 8'(64 + ($urandom % 128)), ra[55:0],
                 rb[63], 8'(64 + ($urandom % 128)), rb[55:0], "R1");
            if ($urandom % 5 == 0) idle(1 + ($urandom % 3));
        end
        idle(6);

        // R10: reset while products are in flight
        send(0, 8'd130, 56'h1, 0, 8'd130, 56'h2, "R10");
        send(0, 8'd131, 56'h3, 0, 8'd131, 56'h4, "R10");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        scb.delete();
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "flush on reset", 64'(out_valid), 64'(0));
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R10", "no stale output", 64'(out_valid), 64'(0));
        end
        send(1, 8'd129, 56'h0, 1, 8'd129, 56'h0, "R9");
        idle(6);
        chk(scb.size() == 0, "R9", "queue drained", 64'(scb.size()), 64'(0));
        report();
    end

endmodule